// File: doc/BRIEF.md
# Strided Vector Prefetch Engine

This block belongs to one processor. It pulls a single strided vector out of a word-interleaved global memory and stores it in a local buffer. Software loads three settings: the element count, the distance between elements, and a per-element enable mask. It then supplies the physical byte address of the first element, and from that point the engine sends one read request per enabled element. Each request carries the element's index as its tag.

Requests only ever carry physical addresses. Because of this, the engine will not step across a 4 KB page by itself. When the next element's address falls in a different page, the engine stops and waits for the processor to provide the physical address of that element.

Replies can come back in any order. Each reply is written into the buffer slot named by its tag. Every slot has a full bit, and the consumer side reads the slots strictly in element order. A word can be read as soon as that particular word is present, even while other requests are still outstanding. The buffer contents stay readable, and can be read again after a rewind, until the next start.

Top module: `vec_prefetch_engine`

## Requirements
- R1: A pulse on `arm_we` stores the length (0 to 512), the stride (counted in 8-byte words) and the mask. These stored values take effect at the next start. A start is `fire_vld` while `paused` is low. Element i of a run lies at the start address plus i·stride·8, with address bits [2:0] forced to zero.
- R2: Enabled elements are requested in increasing index order, and `req_tag` equals the element index.
- R3: An element whose mask bit (mask bit i belongs to element i) is 0 gets no request. Its slot counts as full and reads as zero.
- R4: Suppose the element just handled is not the last one, and the next element's address differs in bits [31:12]. Then `paused` goes high and no request is issued until `fire_vld` arrives. That `fire_vld` supplies the address of the next element, and issuing continues from there.
- R5: A run of 512 elements that stays inside one page issues all 512 requests and never pauses.
- R6: A reply on `rsp_vld` writes `rsp_data` into slot `rsp_tag` and marks that slot full, whatever order the replies arrive in.
- R7: When the read pointer is below the run length, `rd_vld` is high if and only if the slot at the pointer is full, and `rd_wait` is high if and only if that slot is empty. `rd_take` while `rd_vld` is high moves the pointer forward by one.
- R8: A slot that has arrived can be read while other replies of the same run are still outstanding.
- R9: `done` is low after reset. It rises once the last element has been handled and every issued request has been answered, and it stays high until the next start.
- R10: A start empties every enabled slot, sets the read pointer back to zero and clears `done`.
- R11: `rd_rewind` sets the read pointer back to zero and leaves the buffer contents unchanged.
- R12: While `req_vld` is high and `req_rdy` is low, `req_vld`, `req_addr` and `req_tag` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_we | input | 1 | Store length, stride and mask |
| arm_len | input | 10 | Element count, 0 to 512 |
| arm_stride | input | 16 | Element spacing in 8-byte words |
| arm_mask | input | 512 | Per-element enable, bit i for element i |
| fire_vld | input | 1 | Start a run, or resume a paused one |
| fire_addr | input | 32 | Physical byte address for the start or resume |
| req_vld | output | 1 | Read request valid |
| req_rdy | input | 1 | Network accepts the request |
| req_addr | output | 32 | Physical byte address of the element |
| req_tag | output | 9 | Element index |
| rsp_vld | input | 1 | Reply valid |
| rsp_tag | input | 9 | Element index of the reply |
| rsp_data | input | 64 | Reply word |
| rd_take | input | 1 | Consume the word at the read pointer |
| rd_rewind | input | 1 | Move the read pointer back to element 0 |
| rd_vld | output | 1 | Word at the read pointer is present |
| rd_wait | output | 1 | Word at the read pointer has not arrived |
| rd_data | output | 64 | Word at the read pointer |
| paused | output | 1 | Waiting for the next page's address |
| done | output | 1 | All enabled elements have returned |

## Verification
The hardest state to reach from the ports is a partly filled buffer. In that state the consumer sees a later slot full while the slot at its pointer is still empty, so the ordering rule becomes visible. The bench turns off its automatic responder and answers individual tags by hand: first a later element, then element 0. This shows that a stall and an early read can both happen inside one run. Page pauses are produced by starting a few words before a 4 KB boundary and resuming in an unrelated page. An unmasked run that exactly fills a single page tests the opposite boundary.

// File: rtl/pf_pkg.sv
// Shared types for the strided vector prefetch engine.
package pf_pkg;
    // Issue sequencer state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } issue_st_t;

    // Bytes per global-memory word; element addresses are aligned to this.
    localparam int WORD_BYTES = 8;
    localparam int WORD_SHIFT = 3;
endpackage

// File: rtl/pf_issue.sv
// Request sequencer. It steps through the element indices one per cycle.
// An enabled element is held until the network accepts it; a disabled
// element is passed over without a request. Before moving to an element in
// another page it waits in ST_HOLD for a resume address. Counters of sent
// and returned requests produce the completion flag.
// Assumes: no reply is outstanding when a start arrives; replies only
// answer tags issued in the current run.
module pf_issue
    import pf_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int ADDR_W    = 32,
    parameter int STRIDE_W  = 16,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = $clog2(DEPTH),
    parameter int CNT_W     = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                resume,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [CNT_W-1:0]    cfg_len,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [DEPTH-1:0]    elem_mask,
    input  logic                req_rdy,
    input  logic                rsp_vld,
    output logic                req_vld,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [IDX_W-1:0]    req_tag,
    output logic [CNT_W-1:0]    run_len,
    output logic                paused,
    output logic                done
);
    localparam int STEP_W = STRIDE_W + WORD_SHIFT;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

    issue_st_t           st_q;
    logic [IDX_W-1:0]    idx_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   addr_nxt;
    logic [ADDR_W-1:0]   step;
    logic [CNT_W-1:0]    len_q;
    logic [CNT_W-1:0]    len_m1;
    logic [CNT_W-1:0]    sent_q;
    logic [CNT_W-1:0]    back_q;
    logic [STRIDE_W-1:0] stride_q;
    logic                finished_q;
    logic                elem_on;
    logic                at_last;
    logic                crosses;
    logic                advance;
    logic                handshake;

    // Address of the next element and whether it sits in a new page.
    always_comb begin
        step     = ADDR_W'({stride_q, WORD_SHIFT'(0)});
        addr_nxt = addr_q + step;
        crosses  = addr_nxt[ADDR_W-1:PAGE_BITS] != addr_q[ADDR_W-1:PAGE_BITS];
    end

    // Decide whether the current element is finished this cycle.
    always_comb begin
        len_m1    = len_q - CNT_W'(1);
        elem_on   = elem_mask[idx_q];
        at_last   = {1'b0, idx_q} == len_m1;
        advance   = (st_q == ST_RUN) && (!elem_on || req_rdy);
        handshake = req_vld && req_rdy;
    end

    // Sequencer state, element index, current address and latched settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            idx_q      <= '0;
            addr_q     <= '0;
            len_q      <= '0;
            stride_q   <= '0;
            finished_q <= 1'b0;
        end else if (start) begin
            idx_q      <= '0;
            addr_q     <= base_addr & ALIGN_MASK;
            len_q      <= cfg_len;
            stride_q   <= cfg_stride;
            st_q       <= (cfg_len == '0) ? ST_IDLE : ST_RUN;
            finished_q <= (cfg_len == '0);
        end else if (resume) begin
            st_q   <= ST_RUN;
            addr_q <= base_addr & ALIGN_MASK;
        end else if (advance) begin
            if (at_last) begin
                st_q       <= ST_IDLE;
                finished_q <= 1'b1;
            end else begin
                idx_q  <= idx_q + IDX_W'(1);
                addr_q <= addr_nxt;
                if (crosses) begin
                    st_q <= ST_HOLD;
                end
            end
        end
    end

    // Count sent and returned requests of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= '0;
            back_q <= '0;
        end else if (start) begin
            sent_q <= '0;
            back_q <= '0;
        end else begin
            if (handshake) begin
                sent_q <= sent_q + CNT_W'(1);
            end
            if (rsp_vld) begin
                back_q <= back_q + CNT_W'(1);
            end
        end
    end

    assign req_vld  = (st_q == ST_RUN) && elem_on;
    assign req_addr = addr_q;
    assign req_tag  = idx_q;
    assign run_len  = len_q;
    assign paused   = (st_q == ST_HOLD);
    assign done     = finished_q && (sent_q == back_q);

    // R4: accepting a non-final element whose successor is in another page leads to a hold.
    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (handshake && !at_last && crosses && !start) |=> paused);

    // R2: after an accepted request, any following request carries a larger tag.
    p_tag_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (handshake && !start) |=> (!req_vld || (req_tag > $past(req_tag))));

    // R9: done stays high until the next start.
    p_done_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R1: requests only carry word-aligned addresses.
    p_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> (req_addr[WORD_SHIFT-1:0] == '0));
endmodule

// File: rtl/pf_slot_buf.sv
// Prefetch buffer. It holds one data word and one full bit per element.
// A clear empties enabled slots and marks disabled ones full; disabled slots
// read back as zero. Replies write by tag. The read port is combinational,
// indexed by the read pointer.
// Assumes: no reply arrives in the cycle of a clear.
module pf_slot_buf #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [DEPTH-1:0]  new_mask,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DEPTH-1:0]  elem_mask,
    output logic              rd_full,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  full_q;
    logic [DEPTH-1:0]  mask_q;

    // Per-slot full bits: loaded on clear, set by a reply to that slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q[g] <= 1'b0;
            end else if (clear) begin
                full_q[g] <= ~new_mask[g];
            end else if (wr_en && (wr_tag == IDX_W'(g))) begin
                full_q[g] <= 1'b1;
            end
        end
    end

    // Enable mask of the current run, taken at the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clear) begin
            mask_q <= new_mask;
        end
    end

    // Data storage written by reply tag.
    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            mem_q[wr_tag] <= wr_data;
        end
    end

    assign elem_mask = mask_q;
    assign rd_full   = full_q[rd_idx];
    assign rd_data   = mask_q[rd_idx] ? mem_q[rd_idx] : '0;

    // R6: the slot named by a reply is full on the following cycle.
    p_reply_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> full_q[$past(wr_tag)]);

    // R10: after a clear, every enabled slot is empty.
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ((full_q & mask_q) == '0));
endmodule

// File: rtl/pf_read_seq.sv
// In-order read pointer. It exposes the slot at the pointer and moves on
// only when that slot is full and the consumer takes it. A restart (new run
// or rewind) sets the pointer back to element 0.
module pf_read_seq #(
    parameter int DEPTH = 512,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] run_len,
    input  logic             take,
    input  logic             slot_full,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic             rd_wait
);
    logic [CNT_W-1:0] ptr_q;
    logic             in_range;

    // Pointer position relative to the run length.
    always_comb begin
        in_range = ptr_q < run_len;
        rd_vld   = in_range && slot_full;
        rd_wait  = in_range && !slot_full;
        rd_idx   = ptr_q[IDX_W-1:0];
    end

    // Pointer update on restart or on a taken word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (restart) begin
            ptr_q <= '0;
        end else if (take && rd_vld) begin
            ptr_q <= ptr_q + CNT_W'(1);
        end
    end

    // R7: a taken word moves the pointer by exactly one.
    p_take_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rd_vld && !restart) |=> (ptr_q == $past(ptr_q) + CNT_W'(1)));

    // R11: a restart puts the pointer at element 0.
    p_restart_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ptr_q == '0));
endmodule

// File: rtl/vec_prefetch_engine.sv
// Strided vector prefetch engine, top level. Holds the arm settings,
// separates fire pulses into starts and page resumes, and connects the
// sequencer, the buffer and the read pointer.
// Assumes: arm writes land between runs; the network replies once per tag.
module vec_prefetch_engine #(
    parameter int DEPTH      = 512,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int STRIDE_W   = 16,
    parameter int PAGE_BYTES = 4096,
    parameter int IDX_W      = $clog2(DEPTH),
    parameter int CNT_W      = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm_we,
    input  logic [CNT_W-1:0]    arm_len,
    input  logic [STRIDE_W-1:0] arm_stride,
    input  logic [DEPTH-1:0]    arm_mask,
    input  logic                fire_vld,
    input  logic [ADDR_W-1:0]   fire_addr,
    output logic                req_vld,
    input  logic                req_rdy,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [IDX_W-1:0]    req_tag,
    input  logic                rsp_vld,
    input  logic [IDX_W-1:0]    rsp_tag,
    input  logic [DATA_W-1:0]   rsp_data,
    input  logic                rd_take,
    input  logic                rd_rewind,
    output logic                rd_vld,
    output logic                rd_wait,
    output logic [DATA_W-1:0]   rd_data,
    output logic                paused,
    output logic                done
);
    localparam int PAGE_BITS = $clog2(PAGE_BYTES);

    logic [CNT_W-1:0]    len_q;
    logic [STRIDE_W-1:0] stride_q;
    logic [DEPTH-1:0]    mask_q;
    logic                start;
    logic                resume;
    logic [DEPTH-1:0]    run_mask;
    logic [CNT_W-1:0]    run_len;
    logic [IDX_W-1:0]    rd_idx;
    logic                slot_full;

    // Arm settings used by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            stride_q <= '0;
            mask_q   <= '0;
        end else if (arm_we) begin
            len_q    <= arm_len;
            stride_q <= arm_stride;
            mask_q   <= arm_mask;
        end
    end

    // A fire while holding is a resume; any other fire starts a new run.
    always_comb begin
        start  = fire_vld && !paused;
        resume = fire_vld && paused;
    end

    pf_issue #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W),
        .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
        .base_addr(fire_addr), .cfg_len(len_q), .cfg_stride(stride_q),
        .elem_mask(run_mask), .req_rdy(req_rdy), .rsp_vld(rsp_vld),
        .req_vld(req_vld), .req_addr(req_addr), .req_tag(req_tag),
        .run_len(run_len), .paused(paused), .done(done)
    );

    pf_slot_buf #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(start), .new_mask(mask_q),
        .wr_en(rsp_vld), .wr_tag(rsp_tag), .wr_data(rsp_data),
        .rd_idx(rd_idx), .elem_mask(run_mask), .rd_full(slot_full),
        .rd_data(rd_data)
    );

    pf_read_seq #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .restart(start || rd_rewind),
        .run_len(run_len), .take(rd_take), .slot_full(slot_full),
        .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_wait(rd_wait)
    );

    // R12: a request that is not accepted holds steady.
    p_req_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_rdy && !fire_vld) |=>
            (req_vld && $stable(req_addr) && $stable(req_tag)));

    // R10: a start of a non-empty run clears done.
    p_start_clears_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (len_q != '0)) |=> !done);

    // R4: while holding for a resume address nothing is requested.
    p_quiet_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !fire_vld) |=> (paused && !req_vld));
endmodule

// File: tb/sim_vec_prefetch_engine.sv
// Scoreboard bench: prep() pushes the expected requests, the negedge monitor
// pops and compares them, and a responder answers out of order.
module sim_vec_prefetch_engine;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 512;
    localparam int AW     = 32;
    localparam int DW     = 64;
    localparam int SW     = 16;
    localparam int IW     = 9;
    localparam int CW     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_we = 1'b0;
    logic [CW-1:0] arm_len = '0;
    logic [SW-1:0] arm_stride = '0;
    logic [DEPTH-1:0] arm_mask = '0;
    logic          fire_vld = 1'b0;
    logic [AW-1:0] fire_addr = '0;
    logic          req_vld;
    logic          req_rdy = 1'b1;
    logic [AW-1:0] req_addr;
    logic [IW-1:0] req_tag;
    logic          rsp_vld = 1'b0;
    logic [IW-1:0] rsp_tag = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          rd_take = 1'b0;
    logic          rd_rewind = 1'b0;
    logic          rd_vld;
    logic          rd_wait;
    logic [DW-1:0] rd_data;
    logic          paused;
    logic          done;

    vec_prefetch_engine u0 (
        .clk(clk), .rst_n(rst_n), .arm_we(arm_we), .arm_len(arm_len),
        .arm_stride(arm_stride), .arm_mask(arm_mask), .fire_vld(fire_vld),
        .fire_addr(fire_addr), .req_vld(req_vld), .req_rdy(req_rdy),
        .req_addr(req_addr), .req_tag(req_tag), .rsp_vld(rsp_vld),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data), .rd_take(rd_take),
        .rd_rewind(rd_rewind), .rd_vld(rd_vld), .rd_wait(rd_wait),
        .rd_data(rd_data), .paused(paused), .done(done)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [AW-1:0] exp_addr [DEPTH];
    bit            exp_on [DEPTH];
    int            exp_len = 0;
    logic [AW-1:0] q_addr [$];
    int            q_tag [$];
    logic [AW-1:0] res_addr [2];
    int            res_need = 0;
    bit            auto_rsp = 1'b1;
    bit            throttle = 1'b0;
    bit            man_req = 1'b0;
    int            man_tag = 0;
    bit            pend_v [DEPTH];
    logic [AW-1:0] pend_a [DEPTH];
    int            cyc = 0;
    int            pcnt;
    int            phi;
    bit            prev_vld = 1'b0;
    bit            prev_rdy = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    logic [IW-1:0] prev_tag = '0;
    logic [AW-1:0] m_addr;
    int            m_tag;

    function automatic logic [DW-1:0] dval(input logic [AW-1:0] a);
        return {a, a ^ 32'hA5A5_5A5A};
    endfunction

    function automatic logic [DW-1:0] expv(input int i);
        return exp_on[i] ? dval(exp_addr[i]) : '0;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Responder, request-ready driver and request monitor.
    always @(negedge clk) begin
        cyc++;
        rsp_vld = 1'b0;
        if (rst_n) begin
            if (man_req && pend_v[man_tag]) begin
                rsp_vld = 1'b1; rsp_tag = IW'(man_tag);
                rsp_data = dval(pend_a[man_tag]); pend_v[man_tag] = 1'b0;
                man_req = 1'b0;
            end else if (auto_rsp) begin
                pcnt = 0; phi = -1;
                for (int t = 0; t < DEPTH; t++) begin
                    if (pend_v[t]) begin pcnt++; phi = t; end
                end
                if (pcnt >= 3 || (pcnt > 0 && !req_vld)) begin
                    rsp_vld = 1'b1; rsp_tag = IW'(phi);
                    rsp_data = dval(pend_a[phi]); pend_v[phi] = 1'b0;
                end
            end
            req_rdy = throttle ? (cyc % 3 == 0) : 1'b1;
            if (prev_vld && !prev_rdy) begin
                chk(req_vld && req_addr == prev_addr && req_tag == prev_tag,
                    "R12 held request", {req_tag, req_addr}, {prev_tag, prev_addr});
            end
            if (req_vld && req_rdy) begin
                if (q_tag.size() == 0) begin
                    chk(1'b0, "R2 unexpected request", {req_tag, req_addr}, 0);
                end else begin
                    m_addr = q_addr.pop_front(); m_tag = q_tag.pop_front();
                    chk(req_addr == m_addr && req_tag == IW'(m_tag), "R1 R2 request",
                        {req_tag, req_addr}, {IW'(m_tag), m_addr});
                end
                pend_v[req_tag] = 1'b1; pend_a[req_tag] = req_addr;
            end
            prev_vld = req_vld; prev_rdy = req_rdy;
            prev_addr = req_addr; prev_tag = req_tag;
        end
    end

    task automatic fire(input logic [AW-1:0] a);
        fire_vld = 1'b1; fire_addr = a;
        @(negedge clk);
        fire_vld = 1'b0;
    endtask

    // Compute the expected requests and arm the engine.
    task automatic prep(input int len, input int stride, input logic [DEPTH-1:0] mask,
                        input logic [AW-1:0] base, input logic [AW-1:0] r0,
                        input logic [AW-1:0] r1);
        logic [AW-1:0] a;
        logic [AW-1:0] n;
        int k = 0;
        res_addr[0] = r0; res_addr[1] = r1;
        a = {base[AW-1:3], 3'b000};
        for (int i = 0; i < len; i++) begin
            exp_addr[i] = a; exp_on[i] = mask[i];
            if (mask[i]) begin q_addr.push_back(a); q_tag.push_back(i); end
            n = a + AW'(stride * 8);
            if (i < len - 1 && n[AW-1:12] != a[AW-1:12]) begin
                n = {res_addr[k][AW-1:3], 3'b000}; k++;
            end
            a = n;
        end
        res_need = k; exp_len = len;
        arm_we = 1'b1; arm_len = CW'(len); arm_stride = SW'(stride); arm_mask = mask;
        @(negedge clk);
        arm_we = 1'b0;
    endtask

    // Serve page pauses until done; check the pause behaviour and completion.
    task automatic run(input string rq);
        int t = 0;
        int k = 0;
        bit held_ok;
        while (!done && t < 20000) begin
            @(negedge clk); t++;
            if (paused && k < 2) begin
                held_ok = !req_vld;
                repeat (4) begin
                    @(negedge clk);
                    held_ok &= paused && !req_vld;
                end
                chk(held_ok, "R4 quiet while paused", {paused, req_vld}, 2'b10);
                fire(res_addr[k]); k++;
            end
        end
        chk(done, {rq, " done"}, done, 1);
        chk(k == res_need, "R4 pause count", k, res_need);
        chk(q_tag.size() == 0, "R2 all requests issued", q_tag.size(), 0);
    endtask

    task automatic read_all(input string rq);
        for (int i = 0; i < exp_len; i++) begin
            int t = 0;
            while (!rd_vld && t < 2000) begin @(negedge clk); t++; end
            chk(rd_vld && rd_data == expv(i), rq, rd_data, expv(i));
            rd_take = 1'b1;
            @(negedge clk);
            rd_take = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_vld && !done && !paused && !rd_vld, "R9 reset state",
            {req_vld, done, paused, rd_vld}, 0);

        // R1 R3 R6: stride 2, element 3 disabled, unaligned start.
        prep(8, 2, 512'hF7, 32'h0000_1004, 0, 0);
        fire(32'h0000_1004);
        run("R9");
        read_all("R3 R6 read");

        // R4: two elements before a page edge, resume in another page.
        prep(5, 1, 512'h1F, 32'h0000_0FF0, 32'h0000_8000, 0);
        fire(32'h0000_0FF0);
        run("R9");
        read_all("R4 read");

        // R5: 512 elements filling one page exactly.
        prep(512, 1, {DEPTH{1'b1}}, 32'h0001_0000, 0, 0);
        fire(32'h0001_0000);
        run("R5");
        read_all("R5 read");

        // R12: throttled network, stride 3, sparse mask.
        prep(6, 3, 512'h2D, 32'h0000_3000, 0, 0);
        throttle = 1'b1;
        fire(32'h0000_3000);
        run("R12");
        throttle = 1'b0;
        read_all("R12 read");

        // R11: rewind replays the stored words.
        rd_rewind = 1'b1; @(negedge clk); rd_rewind = 1'b0;
        chk(rd_vld && rd_data == expv(0), "R11 rewind first word", rd_data, expv(0));
        read_all("R11 reread");

        // R7 R8 R10: replies released by hand.
        auto_rsp = 1'b0;
        prep(4, 1, 512'hF, 32'h0000_2000, 0, 0);
        fire(32'h0000_2000);
        repeat (8) @(negedge clk);
        chk(!rd_vld && rd_wait, "R10 buffer invalidated", {rd_vld, rd_wait}, 2'b01);
        chk(!done, "R9 not done with replies held", done, 0);
        man_tag = 2; man_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(!rd_vld && rd_wait, "R7 waits on element 0", {rd_vld, rd_wait}, 2'b01);
        man_tag = 0; man_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_vld && rd_data == expv(0) && !done, "R8 early read", rd_data, expv(0));
        auto_rsp = 1'b1;
        run("R9");
        read_all("R6 read");

        // R3: all elements disabled.
        prep(3, 1, 512'h0, 32'h0000_5000, 0, 0);
        fire(32'h0000_5000);
        run("R3");
        read_all("R3 zero read");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule